// File: doc/BRIEF.md
# Configurable Pixel Input Capture Stage

This block sits at the front of a display serial link transmitter. It takes up to two parallel RGB pixels per clock, plus horizontal sync, vertical sync and data-enable, from a display controller. A static strobe-select input chooses whether the data is sampled on the rising or on the falling edge of the pixel clock. Either way, the sampled word is handed on in the rising-edge domain. A static polarity input states which level of data-enable marks active video. The block flips the captured enable where needed, so that downstream logic always sees an active-high enable.

A 2-bit link-mode code selects one of three cases: two pixels in over two links, one pixel in split over two links, or one pixel in over one link. From that code the block derives registered enables for the serial data lanes and the clock lanes. It also derives two controls for the serializer: one marks dual-pixel input and one requests odd/even pixel splitting. A power-up input forces every lane enable to zero, which the output drivers turn into high impedance. The same input also clears the valid flag on the captured word.

Top module: `pixel_capture_stage`

## Requirements
- R1: While `rst` is high at a rising edge, every output is 0 after that edge, including `valid_o`, `lane_oe_o` and `clk_oe_o`.
- R2: With `edge_sel_i` = 1, the pixel, sync and enable inputs present at a rising edge appear on the outputs just after that same edge.
- R3: With `edge_sel_i` = 0, the inputs present at a falling edge appear on the outputs just after the next rising edge. Changes between that falling edge and the rising edge are not seen.
- R4: `de_o` equals `de_i` when `de_pol_i` = 1, and equals the inverse of `de_i` when `de_pol_i` = 0. The same capture edge applies as for the data.
- R5: Mode 2'b11 (two pixels, two links): `dual_pixel_o` = 1, `split_pixels_o` = 0, `pix1_o` carries the captured second pixel, `lane_oe_o` = all ones and `clk_oe_o` = 2'b11 (both clock lanes identical).
- R6: Mode 2'b10 (one pixel, two links): `dual_pixel_o` = 0, `split_pixels_o` = 1, `pix1_o` = 0, `lane_oe_o` = all ones and `clk_oe_o` = 2'b11.
- R7: Mode 2'b00 (one pixel, one link): `dual_pixel_o` = 0, `split_pixels_o` = 0, `pix1_o` = 0, only lanes 0 to 3 enabled (`lane_oe_o` = 8'h0F) and only clock lane 0 (`clk_oe_o` = 2'b01).
- R8: The reserved mode 2'b01 gives exactly the outputs of mode 2'b00.
- R9: After a rising edge at which `pwr_up_i` = 0, `lane_oe_o` = 0, `clk_oe_o` = 0 and `valid_o` = 0. After a rising edge at which `pwr_up_i` = 1 (and no reset), `valid_o` = 1.
- R10: Mode, polarity and power inputs are sampled at the rising edge; all outputs are registered with a latency of one rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| edge_sel_i | input | 1 | 1: sample on rising edge, 0: sample on falling edge |
| de_pol_i | input | 1 | 1: enable active high, 0: enable active low |
| mode_i | input | 2 | Link mode code (11, 10, 00, 01 reserved) |
| pwr_up_i | input | 1 | 0 powers down all serial lanes |
| pix0_i | input | 24 | First pixel, RGB |
| pix1_i | input | 24 | Second pixel, RGB (dual-pixel mode only) |
| hsync_i | input | 1 | Horizontal sync |
| vsync_i | input | 1 | Vertical sync |
| de_i | input | 1 | Data enable, polarity per `de_pol_i` |
| pix0_o | output | 24 | Captured first pixel |
| pix1_o | output | 24 | Captured second pixel, 0 outside dual-pixel mode |
| hsync_o | output | 1 | Captured horizontal sync |
| vsync_o | output | 1 | Captured vertical sync |
| de_o | output | 1 | Captured enable, always active high |
| valid_o | output | 1 | Captured word valid (powered up) |
| dual_pixel_o | output | 1 | Serializer takes two pixels per clock |
| split_pixels_o | output | 1 | Serializer splits odd/even pixels over two links |
| lane_oe_o | output | 8 | Per data lane output enable |
| clk_oe_o | output | 2 | Per clock lane output enable |

## Verification
The bench builds the block with its defaults: 8-bit colour channels, eight data lanes and two clock lanes. With these values the half-link boundary falls at lane 4, so the single-link pattern 8'h0F can be told apart from the dual-link pattern. The 24-bit pixels allow bit patterns that show a mask on the second pixel and an inversion of the enable. Each strobe setting is checked with data that changes on the opposite clock edge. A capture on the wrong edge therefore yields a different word rather than the same one.

// File: rtl/pic_pkg.sv
package pic_pkg;

    typedef enum logic [1:0] {
        MODE_ONE_ONE = 2'b00,
        MODE_RSVD    = 2'b01,
        MODE_ONE_TWO = 2'b10,
        MODE_TWO_TWO = 2'b11
    } link_mode_e;

    typedef struct packed {
        logic dual_pixel;
        logic split_pixels;
        logic second_link;
    } path_ctl_t;

    function automatic path_ctl_t decode_mode(input logic [1:0] code);
        path_ctl_t c;
        c = '0;
        case (link_mode_e'(code))
            MODE_TWO_TWO: begin
                c.dual_pixel  = 1'b1;
                c.second_link = 1'b1;
            end
            MODE_ONE_TWO: begin
                c.split_pixels = 1'b1;
                c.second_link  = 1'b1;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/pic_edge_capture.sv
module pic_edge_capture #(
    parameter int W = 51
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         edge_sel,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] fall_q;

    always_ff @(negedge clk) begin
        if (rst) fall_q <= '0;
        else     fall_q <= d;
    end

    // Rising strobe: live inputs reach the rising-edge register directly.
    assign q = edge_sel ? d : fall_q;
endmodule

// File: rtl/pic_lane_ctrl.sv
module pic_lane_ctrl
    import pic_pkg::*;
#(
    parameter int LANES     = 8,
    parameter int CLK_LANES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           mode,
    input  logic                 pwr_up,
    output path_ctl_t            ctl_now,
    output logic                 valid_q,
    output logic                 dual_pixel_q,
    output logic                 split_q,
    output logic [LANES-1:0]     lane_oe_q,
    output logic [CLK_LANES-1:0] clk_oe_q
);
    localparam int HALF = LANES / 2;

    logic [LANES-1:0]     lane_en;
    logic [CLK_LANES-1:0] clk_en;

    assign ctl_now = decode_mode(mode);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        if (i < HALF) begin : g_first
            assign lane_en[i] = pwr_up;
        end else begin : g_second
            assign lane_en[i] = pwr_up & ctl_now.second_link;
        end
    end

    for (genvar k = 0; k < CLK_LANES; k++) begin : g_clk
        if (k == 0) begin : g_main
            assign clk_en[k] = pwr_up;
        end else begin : g_extra
            assign clk_en[k] = pwr_up & ctl_now.second_link;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q      <= 1'b0;
            dual_pixel_q <= 1'b0;
            split_q      <= 1'b0;
            lane_oe_q    <= '0;
            clk_oe_q     <= '0;
        end else begin
            valid_q      <= pwr_up;
            dual_pixel_q <= ctl_now.dual_pixel;
            split_q      <= ctl_now.split_pixels;
            lane_oe_q    <= lane_en;
            clk_oe_q     <= clk_en;
        end
    end
endmodule

// File: rtl/pixel_capture_stage.sv
module pixel_capture_stage
    import pic_pkg::*;
#(
    parameter int COLOR_W   = 8,
    parameter int LANES     = 8,
    parameter int CLK_LANES = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   edge_sel_i,
    input  logic                   de_pol_i,
    input  logic [1:0]             mode_i,
    input  logic                   pwr_up_i,
    input  logic [3*COLOR_W-1:0]   pix0_i,
    input  logic [3*COLOR_W-1:0]   pix1_i,
    input  logic                   hsync_i,
    input  logic                   vsync_i,
    input  logic                   de_i,
    output logic [3*COLOR_W-1:0]   pix0_o,
    output logic [3*COLOR_W-1:0]   pix1_o,
    output logic                   hsync_o,
    output logic                   vsync_o,
    output logic                   de_o,
    output logic                   valid_o,
    output logic                   dual_pixel_o,
    output logic                   split_pixels_o,
    output logic [LANES-1:0]       lane_oe_o,
    output logic [CLK_LANES-1:0]   clk_oe_o
);
    localparam int PIX_W = 3 * COLOR_W;
    localparam int CAP_W = 2 * PIX_W + 3;

    logic [CAP_W-1:0] raw_word;
    logic [CAP_W-1:0] sel_word;
    path_ctl_t        ctl_now;

    logic [PIX_W-1:0] s_pix0, s_pix1;
    logic             s_hs, s_vs, s_de;

    assign raw_word = {pix0_i, pix1_i, hsync_i, vsync_i, de_i};

    pic_edge_capture #(.W(CAP_W)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .edge_sel (edge_sel_i),
        .d        (raw_word),
        .q        (sel_word)
    );

    pic_lane_ctrl #(.LANES(LANES), .CLK_LANES(CLK_LANES)) u_ctl (
        .clk          (clk),
        .rst          (rst),
        .mode         (mode_i),
        .pwr_up       (pwr_up_i),
        .ctl_now      (ctl_now),
        .valid_q      (valid_o),
        .dual_pixel_q (dual_pixel_o),
        .split_q      (split_pixels_o),
        .lane_oe_q    (lane_oe_o),
        .clk_oe_q     (clk_oe_o)
    );

    assign {s_pix0, s_pix1, s_hs, s_vs, s_de} = sel_word;

    always_ff @(posedge clk) begin
        if (rst) begin
            pix0_o  <= '0;
            pix1_o  <= '0;
            hsync_o <= 1'b0;
            vsync_o <= 1'b0;
            de_o    <= 1'b0;
        end else begin
            pix0_o  <= s_pix0;
            pix1_o  <= ctl_now.dual_pixel ? s_pix1 : '0;
            hsync_o <= s_hs;
            vsync_o <= s_vs;
            de_o    <= s_de ~^ de_pol_i;
        end
    end
endmodule

// File: rtl/pixel_capture_stage_chk.sv
module pixel_capture_stage_chk #(
    parameter int PIX_W     = 24,
    parameter int LANES     = 8,
    parameter int CLK_LANES = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 edge_sel_i,
    input logic                 de_pol_i,
    input logic                 pwr_up_i,
    input logic [PIX_W-1:0]     pix0_i,
    input logic                 de_i,
    input logic [PIX_W-1:0]     pix0_o,
    input logic [PIX_W-1:0]     pix1_o,
    input logic                 de_o,
    input logic                 valid_o,
    input logic                 dual_pixel_o,
    input logic [LANES-1:0]     lane_oe_o,
    input logic [CLK_LANES-1:0] clk_oe_o
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (lane_oe_o == '0 && clk_oe_o == '0 && !valid_o && pix0_o == '0));

    // R2
    rise_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(edge_sel_i)) |-> pix0_o == $past(pix0_i));

    // R4
    de_norm_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(edge_sel_i)) |-> de_o == ($past(de_i) == $past(de_pol_i)));

    // R6
    single_pix1_chk: assert property (@(posedge clk) disable iff (rst)
        !dual_pixel_o |-> pix1_o == '0);

    // R7
    link_pair_chk: assert property (@(posedge clk) disable iff (rst)
        lane_oe_o[LANES-1] == clk_oe_o[CLK_LANES-1]);

    // R9
    power_down_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(pwr_up_i)) |-> (lane_oe_o == '0 && clk_oe_o == '0 && !valid_o));
endmodule

bind pixel_capture_stage pixel_capture_stage_chk #(
    .PIX_W(3 * COLOR_W), .LANES(LANES), .CLK_LANES(CLK_LANES)
) u_chk (
    .clk(clk), .rst(rst), .edge_sel_i(edge_sel_i), .de_pol_i(de_pol_i),
    .pwr_up_i(pwr_up_i), .pix0_i(pix0_i), .de_i(de_i), .pix0_o(pix0_o),
    .pix1_o(pix1_o), .de_o(de_o), .valid_o(valid_o), .dual_pixel_o(dual_pixel_o),
    .lane_oe_o(lane_oe_o), .clk_oe_o(clk_oe_o)
);

// File: tb/pixel_capture_stage_test.sv
module pixel_capture_stage_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        edge_sel_i = 1'b1, de_pol_i = 1'b1, pwr_up_i = 1'b0;
    logic [1:0]  mode_i = 2'b00;
    logic [23:0] pix0_i = '0, pix1_i = '0;
    logic        hsync_i = 1'b0, vsync_i = 1'b0, de_i = 1'b0;
    logic [23:0] pix0_o, pix1_o;
    logic        hsync_o, vsync_o, de_o, valid_o, dual_pixel_o, split_pixels_o;
    logic [7:0]  lane_oe_o;
    logic [1:0]  clk_oe_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pixel_capture_stage uut (.*);

    // Top byte: [7] edge, [6] de polarity, [5:4] mode, [3] power, [2] hs, [1] vs, [0] de
    localparam logic [55:0] VEC [8] = '{
        56'hFD_A1B2C3_D4E5F6,
        56'hAB_123456_789ABC,
        56'h4E_0F1E2D_3C4B5A,
        56'h18_FFFFFF_000001,
        56'hC7_55AA55_AA55AA,
        56'h7B_800001_7FFFFE,
        56'h21_13579B_2468AC,
        56'h9C_C0FFEE_BADC0D
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [55:0] v, input bit invert);
        logic [55:0] w;
        w = invert ? ~v : v;
        if (!invert) begin
            edge_sel_i = v[55]; de_pol_i = v[54]; mode_i = v[53:52]; pwr_up_i = v[51];
        end
        hsync_i = w[50]; vsync_i = w[49]; de_i = w[48];
        pix0_i = w[47:24]; pix1_i = w[23:0];
    endtask

    string dreq, mreq;

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        chk("R1 pix0", 64'(pix0_o), 0);
        chk("R1 pix1", 64'(pix1_o), 0);
        chk("R1 sync/de/valid", 64'({hsync_o, vsync_o, de_o, valid_o}), 0);
        chk("R1 lanes", 64'({lane_oe_o, clk_oe_o}), 0);
        chk("R1 path", 64'({dual_pixel_o, split_pixels_o}), 0);
        rst = 1'b0;

        for (int i = 0; i < 8; i++) begin
            logic [55:0] v;
            logic [1:0]  m;
            logic        two;
            v = VEC[i];
            m = v[53:52];
            two = m[1];
            if (v[55]) begin
                @(negedge clk); #1; apply(v, 1'b0);
                @(posedge clk); #1;
                dreq = "R2";
            end else begin
                @(posedge clk); #1; apply(v, 1'b0);
                @(negedge clk); #1; apply(v, 1'b1);
                @(posedge clk); #1;
                dreq = "R3";
            end
            case (m)
                2'b11: mreq = "R5";
                2'b10: mreq = "R6";
                2'b00: mreq = "R7";
                default: mreq = "R8";
            endcase
            chk({dreq, " pix0"}, 64'(pix0_o), 64'(v[47:24]));
            chk({dreq, " sync"}, 64'({hsync_o, vsync_o}), 64'(v[50:49]));
            chk("R4 de", 64'(de_o), 64'(v[48] == v[54]));
            chk({mreq, " pix1"}, 64'(pix1_o), (m == 2'b11) ? 64'(v[23:0]) : 64'(0));
            chk({mreq, " path"}, 64'({dual_pixel_o, split_pixels_o}),
                64'({m == 2'b11, m == 2'b10}));
            chk({mreq, " R9 lanes"}, 64'({lane_oe_o, clk_oe_o}),
                !v[51] ? 64'(0) : (two ? 64'({8'hFF, 2'b11}) : 64'({8'h0F, 2'b01})));
            chk("R9 valid", 64'(valid_o), 64'(v[51]));
        end

        // R9/R10: power toggles take one rising edge
        @(negedge clk); edge_sel_i = 1'b1; mode_i = 2'b11; pwr_up_i = 1'b0;
        @(posedge clk); #1;
        chk("R9 off", 64'({valid_o, lane_oe_o, clk_oe_o}), 0);
        @(negedge clk); pwr_up_i = 1'b1;
        #1 chk("R10 held", 64'(valid_o), 0);
        @(posedge clk); #1;
        chk("R9 on", 64'({valid_o, lane_oe_o, clk_oe_o}), 64'({1'b1, 8'hFF, 2'b11}));

        // R8: reserved code matches single link, with second pixel masked
        @(negedge clk); mode_i = 2'b01; pix1_i = 24'hFFFFFF;
        @(posedge clk); #1;
        chk("R8 lanes", 64'({lane_oe_o, clk_oe_o}), 64'({8'h0F, 2'b01}));
        chk("R8 pix1", 64'(pix1_o), 0);

        // R1: reset applied mid-run
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        chk("R1 midrun", 64'({valid_o, lane_oe_o, clk_oe_o, pix0_o}), 0);
        rst = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule